// File: doc/BRIEF.md
# Floating-Point Status and Exception-Control Register

This block keeps the status and control state that sits next to a floating-point datapath. It holds a rounding-mode selection, a control that makes the datapath treat denormal operands as zero, one enable for each of the five IEEE-754 exceptions, and six cause flags. Five of the cause flags track the IEEE-754 exceptions. The sixth records unimplemented processing. The mode bits go straight to the datapath as plain outputs.

Each completed floating-point operation presents its raw exception indications with a one-cycle strobe. The block replaces the cause flags with that operation's indications. In the next cycle it raises a one-cycle exception request if an enabled exception or unimplemented processing occurred. Software uses a plain write strobe and a combinational read bus. A software write can only clear cause flags and can never set them. Neither side has back-pressure: the operation strobe and the write strobe are each taken in the cycle they are high. There is no valid/ready handshake, because the block always accepts both.

Top module: `fpsr_unit`

## Requirements
- R1: After reset the read bus is all zero, the rounding mode is 00 (nearest, ties to even), the denormal flush output is 0 and the exception request is low.
- R2: Bits [1:0] of the register select the rounding mode: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. A write sets this field, and `round_mode` and the read bus show it from the next cycle.
- R3: Bit 2 is the denormal flush control. 0 keeps denormal operands as denormals and 1 makes the datapath treat them as zero. It is written and read like the mode field and drives `flush_denorm`.
- R4: Bits [8:4] are the exception enables for invalid operation, overflow, division by zero, underflow and inexact, at bit 4 through bit 8 in that order. A write sets them and they read back.
- R5: Bits [15:10] are the cause flags for invalid, overflow, division by zero, underflow, inexact and unimplemented processing, at bit 10 through bit 15 in that order. An operation strobe clears every flag that is set, then records that operation's six indications (`fpu_op_flags` bit i maps to cause bit 10+i).
- R6: A software write with no operation strobe clears a cause flag where the written bit is 0 and keeps the flag where the written bit is 1. A write never sets a cause flag.
- R7: The exception request is raised for an operation when one of its five IEEE-754 indications has its enable at 1. Operations whose IEEE indications are all masked do not raise it. The enables used are the ones held before that cycle's clock edge.
- R8: An operation that indicates unimplemented processing always raises the exception request, whatever the enables are.
- R9: When a software write and an operation strobe fall in the same cycle, the operation sets the cause flags, and the write still updates the mode, flush and enable fields.
- R10: The exception request is high for exactly the one cycle that follows an operation strobe that qualifies under R7 or R8, and low in every other cycle.
- R11: Reserved bits (3, 9 and 31:16) always read 0, even after all ones are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_data | output | 32 | Register contents, combinational |
| fpu_op_valid | input | 1 | Strobe: an operation completed this cycle |
| fpu_op_flags | input | 6 | Raw indications: invalid, overflow, div-zero, underflow, inexact, unimplemented (bit 0 to bit 5) |
| round_mode | output | 2 | Current rounding-mode selection |
| flush_denorm | output | 1 | Denormal flush-to-zero control |
| fpu_exc_req | output | 1 | One-cycle exception request |

## Verification
A software write and an operation strobe can fall in the same cycle. The write then tries to clear cause flags and change the enables while the operation tries to record new flags and decide on a trap. The bench loads all cause flags as set and arms one enable pattern. It then raises both strobes in one cycle, with a write that clears every cause bit and installs a different enable pattern, and sweeps all 64 operation indications. It expects the cause field to equal the operation's indications, the mode and enables to carry the written values, and the request to follow the old enables.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int REG_W     = 32;
  localparam int RM_W      = 2;
  localparam int N_IEEE    = 5;
  localparam int N_CAUSE   = N_IEEE + 1;
  localparam int RM_LSB    = 0;
  localparam int FLUSH_BIT = 2;
  localparam int EN_LSB    = 4;
  localparam int CAUSE_LSB = 10;
  localparam int C_UNIMPL  = N_IEEE;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_PINF    = 2'b10,
    RM_NINF    = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpsr_ctrl_regs.sv
module fpsr_ctrl_regs
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RM_W-1:0]   wr_rmode,
  input  logic              wr_flush,
  input  logic [N_IEEE-1:0] wr_enables,
  output logic [RM_W-1:0]   rmode,
  output logic              flush,
  output logic [N_IEEE-1:0] enables
);
  rmode_e rmode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmode_q <= RM_NEAREST;
      flush   <= 1'b0;
      enables <= '0;
    end else if (wr_en) begin
      rmode_q <= rmode_e'(wr_rmode);
      flush   <= wr_flush;
      enables <= wr_enables;
    end
  end

  assign rmode = rmode_q;

  // Control fields move only on a software write (R2, R3, R4)
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rmode) && $stable(flush) && $stable(enables)));
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rmode == $past(wr_rmode)));
endmodule

// File: rtl/fpsr_cause_flags.sv
module fpsr_cause_flags
  import fpsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [N_CAUSE-1:0] op_flags,
  input  logic               wr_en,
  input  logic [N_CAUSE-1:0] wr_keep,
  output logic [N_CAUSE-1:0] cause
);
  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rst_n)        cause[i] <= 1'b0;
      else if (op_valid) cause[i] <= op_flags[i];
      else if (wr_en)    cause[i] <= cause[i] & wr_keep[i];
    end
  end

  // Operation replaces the flags, and wins a collision (R5, R9)
  p_op_replaces_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (cause == $past(op_flags)));
  // Software can only clear (R6)
  p_sw_never_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && wr_en) |=> ((cause & ~$past(cause)) == '0));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en) |=> $stable(cause));
endmodule

// File: rtl/fpsr_trap_gen.sv
module fpsr_trap_gen
  import fpsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [N_CAUSE-1:0] op_flags,
  input  logic [N_IEEE-1:0]  enables,
  output logic               exc_req
);
  logic hit_ieee;
  logic hit_unimpl;

  assign hit_ieee   = |(op_flags[N_IEEE-1:0] & enables);
  assign hit_unimpl = op_flags[C_UNIMPL];

  always_ff @(posedge clk) begin
    if (!rst_n) exc_req <= 1'b0;
    else        exc_req <= op_valid && (hit_ieee || hit_unimpl);
  end

  // Unimplemented processing cannot be masked (R8)
  p_unimpl_traps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_flags[C_UNIMPL]) |=> exc_req);
  // Request only follows an operation strobe (R10)
  p_req_after_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(op_valid));
  // Fully masked operation gives no request (R7)
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_flags[C_UNIMPL] && ((op_flags[N_IEEE-1:0] & enables) == '0))
      |=> !exc_req);
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [31:0] sw_wr_data,
  output logic [31:0] sw_rd_data,
  input  logic        fpu_op_valid,
  input  logic [5:0]  fpu_op_flags,
  output logic [1:0]  round_mode,
  output logic        flush_denorm,
  output logic        fpu_exc_req
);
  logic [N_IEEE-1:0]  enables;
  logic [N_CAUSE-1:0] cause;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{sw_wr_data[REG_W-1:CAUSE_LSB+N_CAUSE],
                            sw_wr_data[EN_LSB+N_IEEE], sw_wr_data[FLUSH_BIT+1]};

  fpsr_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (sw_wr_en),
    .wr_rmode   (sw_wr_data[RM_LSB +: RM_W]),
    .wr_flush   (sw_wr_data[FLUSH_BIT]),
    .wr_enables (sw_wr_data[EN_LSB +: N_IEEE]),
    .rmode      (round_mode),
    .flush      (flush_denorm),
    .enables    (enables)
  );

  fpsr_cause_flags u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (fpu_op_valid),
    .op_flags (fpu_op_flags),
    .wr_en    (sw_wr_en),
    .wr_keep  (sw_wr_data[CAUSE_LSB +: N_CAUSE]),
    .cause    (cause)
  );

  fpsr_trap_gen u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (fpu_op_valid),
    .op_flags (fpu_op_flags),
    .enables  (enables),
    .exc_req  (fpu_exc_req)
  );

  always_comb begin
    sw_rd_data                        = '0;
    sw_rd_data[RM_LSB +: RM_W]        = round_mode;
    sw_rd_data[FLUSH_BIT]             = flush_denorm;
    sw_rd_data[EN_LSB +: N_IEEE]      = enables;
    sw_rd_data[CAUSE_LSB +: N_CAUSE]  = cause;
  end

  // Reserved bits stay zero (R11)
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_data & 32'hFFFF_0208) == 32'h0);
endmodule

// File: tb/fpsr_unit_bench.sv
`timescale 1ns/1ps
module fpsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] sw_rd_data;
  logic        fpu_op_valid = 1'b0;
  logic [5:0]  fpu_op_flags = '0;
  logic [1:0]  round_mode;
  logic        flush_denorm;
  logic        fpu_exc_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpsr_unit u_fpsr_unit (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .fpu_op_valid(fpu_op_valid), .fpu_op_flags(fpu_op_flags),
    .round_mode(round_mode), .flush_denorm(flush_denorm), .fpu_exc_req(fpu_exc_req)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [1:0] rm, input logic fl,
                                       input logic [4:0] en, input logic [5:0] ca);
    return {16'h0, ca, 1'b0, en, 1'b0, fl, rm};
  endfunction

  function automatic logic [5:0] cause_of(input logic [31:0] r);
    return r[15:10];
  endfunction

  function automatic logic trap_exp(input logic [5:0] f, input logic [4:0] en);
    return ((f[4:0] & en) != 5'd0) || f[5];
  endfunction

  task automatic sw_write(input logic [31:0] d);
    sw_wr_en = 1'b1; sw_wr_data = d;
    @(negedge clk);
    sw_wr_en = 1'b0; sw_wr_data = '0;
  endtask

  task automatic fpu_op(input logic [5:0] f);
    fpu_op_valid = 1'b1; fpu_op_flags = f;
    @(negedge clk);
    fpu_op_valid = 1'b0; fpu_op_flags = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sw_rd_data == 32'h0, "R1", sw_rd_data, 32'h0);
    chk(round_mode == 2'b00 && flush_denorm == 1'b0, "R1", {round_mode, flush_denorm}, 0);
    chk(fpu_exc_req == 1'b0, "R1", fpu_exc_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw_rd_data == 32'h0, "R1", sw_rd_data, 32'h0);

    // R2, R3 mode and flush sweep
    for (int rm = 0; rm < 4; rm++) begin
      for (int fl = 0; fl < 2; fl++) begin
        sw_write(pack(rm[1:0], fl[0], 5'd0, 6'd0));
        chk(round_mode == rm[1:0] && sw_rd_data[1:0] == rm[1:0], "R2", round_mode, rm);
        chk(flush_denorm == fl[0] && sw_rd_data[2] == fl[0], "R3", flush_denorm, fl);
      end
    end

    // R4, R5, R7, R8, R10 exhaustive over enables x indications
    for (int en = 0; en < 32; en++) begin
      sw_write(pack(2'b00, 1'b0, en[4:0], 6'd0));
      chk(sw_rd_data[8:4] == en[4:0], "R4", sw_rd_data[8:4], en);
      for (int f = 0; f < 64; f++) begin
        fpu_op(f[5:0]);
        chk(cause_of(sw_rd_data) == f[5:0], "R5", cause_of(sw_rd_data), f);
        if (f[5])
          chk(fpu_exc_req == 1'b1, "R8", fpu_exc_req, 1);
        else
          chk(fpu_exc_req == trap_exp(f[5:0], en[4:0]), "R7", fpu_exc_req,
              trap_exp(f[5:0], en[4:0]));
        @(negedge clk);
        chk(fpu_exc_req == 1'b0, "R10", fpu_exc_req, 0);
      end
    end

    // R6 clear-only software writes
    for (int p = 0; p < 64; p++) begin
      for (int w = 0; w < 64; w++) begin
        fpu_op(p[5:0]);
        sw_write(pack(2'b01, 1'b1, 5'h1F, w[5:0]));
        chk(cause_of(sw_rd_data) == (p[5:0] & w[5:0]), "R6", cause_of(sw_rd_data),
            p[5:0] & w[5:0]);
      end
    end

    // R9 collision of write and operation
    for (int f = 0; f < 64; f++) begin
      sw_write(pack(2'b00, 1'b0, 5'h15, 6'd0));
      fpu_op(6'h3F);
      @(negedge clk);
      sw_wr_en = 1'b1; sw_wr_data = pack(2'b11, 1'b1, 5'h0A, 6'd0);
      fpu_op_valid = 1'b1; fpu_op_flags = f[5:0];
      @(negedge clk);
      sw_wr_en = 1'b0; sw_wr_data = '0; fpu_op_valid = 1'b0; fpu_op_flags = '0;
      chk(cause_of(sw_rd_data) == f[5:0], "R9", cause_of(sw_rd_data), f);
      chk(round_mode == 2'b11 && flush_denorm && sw_rd_data[8:4] == 5'h0A, "R9",
          sw_rd_data[8:0], {5'h0A, 1'b0, 1'b1, 2'b11});
      chk(fpu_exc_req == trap_exp(f[5:0], 5'h15), "R7", fpu_exc_req,
          trap_exp(f[5:0], 5'h15));
    end

    // R11 reserved bits
    fpu_op(6'h2A);
    sw_write(32'hFFFF_FFFF);
    chk((sw_rd_data & 32'hFFFF_0208) == 32'h0, "R11", sw_rd_data, sw_rd_data & ~32'hFFFF_0208);
    chk(sw_rd_data == pack(2'b11, 1'b1, 5'h1F, 6'h2A), "R11", sw_rd_data,
        pack(2'b11, 1'b1, 5'h1F, 6'h2A));

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule